// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer for Two Channels

This block is the digital controller of a dual-slope analog-to-digital converter that one integrator shares between two input channels. For each conversion it discharges the integrator for a fixed settling time. It then connects the selected channel input for exactly 2^N clock cycles. Last, it connects the negative reference and counts clock cycles until the external comparator reports that the integrator output has crossed zero. That count is the conversion result. It equals the ratio of input to reference, scaled to 2^N.

While the run enable stays high, conversions follow one another with no gap other than the discharge time. The channel alternates strictly: channel 0 first after a start, then channel 1, and so on. A downstream averaging filter therefore receives an unbroken stream of samples for each channel, and every sample is tagged with its channel.

The comparator passes through a two-flop synchronizer. The fixed latency of that synchronizer is subtracted from the count, so the result counts the de-integration cycles that ended before the comparator first read high. The converter cannot pause in mid-integration, so the result port is a valid-only stream with no ready input. The sink must accept every cycle in which the valid strobe is high, and back-pressure is not possible.

Top module: `dsadc_seq`

## Requirements
- R1: After reset, int_rst is 1, sel_input, sel_ref, res_valid and chan_sel are 0, and the block stays idle until run_en is 1.
- R2: At most one of int_rst, sel_input and sel_ref is high in any cycle.
- R3: The input phase (sel_input high) lasts exactly 2^N consecutive cycles.
- R4: chan_sel holds steady through a conversion. It is 0 for the first conversion after a start and inverts for each following conversion while run_en stays high. res_chan carries the channel of the conversion it reports.
- R5: The reference phase (sel_ref high) starts in the cycle right after the input phase ends. Let C be the index of the first reference-phase cycle (the first such cycle is index 0) at whose closing clock edge cmp_raw is sampled 1. Then res_data equals C and res_over is 0.
- R6: res_valid is high for exactly one cycle per conversion, in the cycle after the reference phase ends.
- R7: If cmp_raw is not sampled high in any of the first 2^N reference-phase cycles, then res_data is 2^N-1 (all ones) and res_over is 1. A crossing at index 2^N-1 gives res_data 2^N-1 and res_over 0.
- R8: If run_en falls during a conversion, that conversion completes and its result is delivered. The block then idles with int_rst high and neither select high. The next start begins with channel 0.
- R9: Between back-to-back conversions, int_rst is high for exactly RST_CYC cycles.
- R10: A high cmp_raw during the discharge or input phase has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Keeps conversions running while high |
| cmp_raw | input | 1 | Asynchronous comparator output, 1 when the zero crossing has happened |
| sel_input | output | 1 | Connects the selected channel input to the integrator |
| sel_ref | output | 1 | Connects the negative reference to the integrator |
| int_rst | output | 1 | Discharges the integrator |
| chan_sel | output | 1 | Channel being converted (0 or 1) |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | N | De-integration count |
| res_chan | output | 1 | Channel of the result |
| res_over | output | 1 | Overrange: no crossing within full scale |

## Verification
The assertions assume that rst_n is held low long enough for the synchronizer to clear. They make no assumption about cmp_raw, because the sequencing they check does not depend on when the crossing comes. The stimulus drives cmp_raw on falling edges only, so the synchronizer always samples a settled level. It keeps cmp_raw low during the reference phase until the chosen crossing index and high after it, which models a monotonic integrator ramp. It deliberately holds cmp_raw high during the input phase in one scenario.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DISCH = 2'd1,
    ST_INTEG = 2'd2,
    ST_DEINT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int N       = 10,
  parameter int RST_CYC = 4,
  parameter int LAT     = 2,
  localparam int CW     = N + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          hit,
  output logic          sel_input,
  output logic          sel_ref,
  output logic          int_rst,
  output logic          chan,
  output logic          conv_end,
  output logic          conv_over,
  output logic [CW-1:0] cnt
);
  localparam int FULL = 2 ** N;
  localparam logic [CW-1:0] DISCH_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] INTEG_LAST = CW'(FULL - 1);
  localparam logic [CW-1:0] DEINT_LAST = CW'(FULL + LAT - 1);
  localparam logic [CW-1:0] LAT_MIN    = CW'(LAT);

  seq_state_e state;
  logic       hit_ok;

  // a crossing is only trusted once the synchronizer carries reference-phase samples
  assign hit_ok    = (state == ST_DEINT) && hit && (cnt >= LAT_MIN);
  assign conv_over = (state == ST_DEINT) && !hit_ok && (cnt == DEINT_LAST);
  assign conv_end  = hit_ok || conv_over;

  assign int_rst   = (state == ST_IDLE) || (state == ST_DISCH);
  assign sel_input = (state == ST_INTEG);
  assign sel_ref   = (state == ST_DEINT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      chan  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt  <= '0;
          chan <= 1'b0;
          if (run_en) state <= ST_DISCH;
        end
        ST_DISCH: begin
          if (cnt == DISCH_LAST) begin
            cnt   <= '0;
            state <= ST_INTEG;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_INTEG: begin
          if (cnt == INTEG_LAST) begin
            cnt   <= '0;
            state <= ST_DEINT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DEINT: begin
          if (conv_end) begin
            cnt <= '0;
            if (run_en) begin
              state <= ST_DISCH;
              chan  <= ~chan;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
  parameter int N   = 10,
  parameter int LAT = 2,
  localparam int CW = N + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_end,
  input  logic          conv_over,
  input  logic          chan,
  input  logic [CW-1:0] cnt,
  output logic          res_valid,
  output logic [N-1:0]  res_data,
  output logic          res_chan,
  output logic          res_over
);
  logic [CW-1:0] comp;
  logic [N-1:0]  value;

  assign comp  = cnt - CW'(LAT);
  assign value = conv_over ? {N{1'b1}} : comp[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= 1'b0;
      res_over  <= 1'b0;
    end else begin
      res_valid <= conv_end;
      if (conv_end) begin
        res_data <= value;
        res_chan <= chan;
        res_over <= conv_over;
      end
    end
  end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
  parameter int N       = 10,
  parameter int RST_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         cmp_raw,
  output logic         sel_input,
  output logic         sel_ref,
  output logic         int_rst,
  output logic         chan_sel,
  output logic         res_valid,
  output logic [N-1:0] res_data,
  output logic         res_chan,
  output logic         res_over
);
  localparam int SYNC = 2;
  localparam int CW   = N + 2;

  logic          cmp_s;
  logic          conv_end;
  logic          conv_over;
  logic [CW-1:0] cnt;

  dsadc_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cmp_raw),
    .q    (cmp_s)
  );

  dsadc_ctrl #(.N(N), .RST_CYC(RST_CYC), .LAT(SYNC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .hit      (cmp_s),
    .sel_input(sel_input),
    .sel_ref  (sel_ref),
    .int_rst  (int_rst),
    .chan     (chan_sel),
    .conv_end (conv_end),
    .conv_over(conv_over),
    .cnt      (cnt)
  );

  dsadc_result #(.N(N), .LAT(SYNC)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_end (conv_end),
    .conv_over(conv_over),
    .chan     (chan_sel),
    .cnt      (cnt),
    .res_valid(res_valid),
    .res_data (res_data),
    .res_chan (res_chan),
    .res_over (res_over)
  );
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int N       = 10,
  parameter int RST_CYC = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_input,
  input logic         sel_ref,
  input logic         int_rst,
  input logic         chan_sel,
  input logic         res_valid,
  input logic [N-1:0] res_data,
  input logic         res_over
);
  localparam int FULL = 2 ** N;
  logic [N+1:0] in_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_run <= '0;
    else if (sel_input) in_run <= in_run + 1'b1;
    else                in_run <= '0;
  end

  a_r2_switch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_rst, sel_input, sel_ref}));

  a_r3_integ_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_input) |-> (in_run == (N+2)'(FULL)));

  a_r5_ref_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_input) |-> sel_ref);

  a_r4_chan_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ref && $past(sel_ref || sel_input)) |-> $stable(chan_sel));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r6_valid_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $fell(sel_ref));

  a_r7_over_full: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_over) |-> (res_data == {N{1'b1}}));
endmodule

bind dsadc_seq dsadc_seq_chk #(.N(N), .RST_CYC(RST_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_input(sel_input),
  .sel_ref  (sel_ref),
  .int_rst  (int_rst),
  .chan_sel (chan_sel),
  .res_valid(res_valid),
  .res_data (res_data),
  .res_over (res_over)
);

// File: tb/dsadc_seq_tb.sv
`timescale 1ns/1ps
module dsadc_seq_tb;
  localparam int N    = 5;
  localparam int RC   = 4;
  localparam int FULL = 2 ** N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic cmp_raw = 1'b0;
  logic sel_input, sel_ref, int_rst, chan_sel, res_valid, res_chan, res_over;
  logic [N-1:0] res_data;

  always #2 clk = ~clk;

  dsadc_seq #(.N(N), .RST_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmp_raw(cmp_raw),
    .sel_input(sel_input), .sel_ref(sel_ref), .int_rst(int_rst),
    .chan_sel(chan_sel), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .res_over(res_over)
  );

  int checks = 0;
  int errors = 0;

  int cross_tbl [0:31];
  int conv_i = 0;
  int k = 0;
  bit noise = 0;
  int got_n = 0;
  int got_data [0:31];
  int got_chan [0:31];
  int got_over [0:31];
  int integ_run = 0, last_integ = 0;
  int rst_run = 0, last_rst = 0;
  bit after_ref = 0;
  int overlap = 0, dbl = 0;
  bit p_in = 0, p_ref = 0, p_val = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stimulus and observer, acting on falling edges only
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if ((int'(sel_input) + int'(sel_ref) + int'(int_rst)) > 1) overlap++;
        if (sel_ref) begin
          cmp_raw = (k >= cross_tbl[conv_i]);
          k++;
        end else if (sel_input) begin
          cmp_raw = noise;
        end else begin
          cmp_raw = 1'b0;
        end
        if (p_ref && !sel_ref) begin
          conv_i++;
          k = 0;
          after_ref = 1;
          rst_run = 0;
          cmp_raw = 1'b0;
        end
        if (sel_input) integ_run++;
        else if (p_in) begin last_integ = integ_run; integ_run = 0; end
        if (int_rst && after_ref) rst_run++;
        if (sel_input && !p_in && after_ref) begin last_rst = rst_run; after_ref = 0; end
        if (res_valid) begin
          if (p_val) dbl++;
          got_data[got_n] = int'(res_data);
          got_chan[got_n] = int'(res_chan);
          got_over[got_n] = int'(res_over);
          got_n++;
        end
        p_in = sel_input; p_ref = sel_ref; p_val = res_valid;
      end
    end
  end

  task automatic wait_results(input int target);
    while (got_n < target) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(int_rst == 1'b1, "R1 int_rst", int'(int_rst), 1);
    check(!sel_input && !sel_ref, "R1 selects", int'({sel_input, sel_ref}), 0);
    check(!res_valid && !chan_sel, "R1 valid/chan", int'({res_valid, chan_sel}), 0);
    repeat (20) @(negedge clk);
    check(!sel_input && int_rst, "R1 idle without run_en", int'(sel_input), 0);
  endtask

  task automatic test_stream();
    int base = got_n;
    int exp_c [4] = '{0, 7, 20, 3};
    for (int i = 0; i < 4; i++) cross_tbl[conv_i + i] = exp_c[i];
    run_en = 1'b1;
    wait_results(base + 3);
    run_en = 1'b0;
    wait_results(base + 4);
    for (int i = 0; i < 4; i++) begin
      check(got_data[base+i] == exp_c[i], "R5 count", got_data[base+i], exp_c[i]);
      check(got_over[base+i] == 0, "R5 no over", got_over[base+i], 0);
      check(got_chan[base+i] == (i % 2), "R4 channel", got_chan[base+i], i % 2);
    end
    check(last_integ == FULL, "R3 input phase length", last_integ, FULL);
    check(last_rst == RC, "R9 discharge length", last_rst, RC);
    repeat (100) @(negedge clk);
    check(got_n == base + 4, "R8 stop after current", got_n, base + 4);
    check(int_rst && !sel_input && !sel_ref, "R8 idle", int'({int_rst, sel_input, sel_ref}), 4);
    check(chan_sel == 1'b0, "R8 chan cleared", int'(chan_sel), 0);
  endtask

  task automatic test_bounds();
    int base = got_n;
    cross_tbl[conv_i]     = FULL - 1;
    cross_tbl[conv_i + 1] = FULL;
    cross_tbl[conv_i + 2] = 1000;
    run_en = 1'b1;
    wait_results(base + 2);
    run_en = 1'b0;
    wait_results(base + 3);
    check(got_data[base] == FULL - 1 && got_over[base] == 0, "R7 last in range",
          got_data[base] * 2 + got_over[base], (FULL - 1) * 2);
    check(got_data[base+1] == FULL - 1 && got_over[base+1] == 1, "R7 overrange at full",
          got_data[base+1] * 2 + got_over[base+1], (FULL - 1) * 2 + 1);
    check(got_data[base+2] == FULL - 1 && got_over[base+2] == 1, "R7 never crosses",
          got_data[base+2] * 2 + got_over[base+2], (FULL - 1) * 2 + 1);
    check(got_chan[base] == 0, "R8 restart on channel 0", got_chan[base], 0);
    repeat (60) @(negedge clk);
  endtask

  task automatic test_noise();
    int base = got_n;
    noise = 1;
    cross_tbl[conv_i]     = 5;
    cross_tbl[conv_i + 1] = 0;
    run_en = 1'b1;
    wait_results(base + 1);
    run_en = 1'b0;
    wait_results(base + 2);
    noise = 0;
    check(got_data[base] == 5, "R10 input-phase comparator ignored", got_data[base], 5);
    check(got_data[base+1] == 0 && got_over[base+1] == 0, "R10 zero count",
          got_data[base+1], 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) cross_tbl[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_stream();
    test_bounds();
    test_noise();
    check(overlap == 0, "R2 switch exclusivity", overlap, 0);
    check(dbl == 0, "R6 one-cycle strobe", dbl, 0);
    check(got_n == conv_i, "R6 one result per conversion", got_n, conv_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", got_n, conv_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule